// File: doc/BRIEF.md
# JTAG Scan Master Engine

This block is a master for a four-signal test access port. A host issues one request at a time on a small command interface: a port reset, an 8-bit instruction scan, or a 16-bit or 20-bit data scan. The engine then runs the whole scan on its own. It generates the TMS navigation pattern from the idle state and shifts the request word out on TDI, most significant bit first. It collects TDO into a left-shifting register, returns to idle, and presents the captured word together with a single-cycle done pulse.

TCK comes from dividing the system clock by a parameterized half-period and rests low between operations. A port reset request also runs a fuse-check pulse train on TMS. During this train TCK does not toggle, and each low pulse lasts a programmable number of system clocks. The result of a 20-bit data scan is rotated before it is returned, so the host receives it in the target's native field order.

Top module: `jtag_scan_master`

## Requirements
- R1: After synchronous reset, busy and done are 0, TCK is 0 and TMS is 1.
- R2: An instruction scan (req_op = 1) gives 13 TCK cycles. TMS is 1,1,0,0 on the first four. TMS is 0 on the next seven and 1 on the twelfth, which is the eighth shifted bit. TMS is 0 on the last cycle.
- R3: A data scan (req_op = 2 for 16 bits, 3 for 20 bits) gives TMS 1,0,0. The shift cycles follow, with TMS high only on the final shifted bit. One more cycle has TMS 0. That makes 20 or 24 TCK cycles in total.
- R4: During shift cycle k (counting from 0), TDI carries request bit L-1-k, where L is the scan length.
- R5: TDO is sampled once per shift cycle, as TCK falls, into bit 0 of a left-shifting register. For 8- and 16-bit scans, rsp_data holds the captured bits in its low L bits and zeros above them.
- R6: For a 20-bit scan, with w the raw capture, rsp_data is {w[3:0], w[19:4]}. This is w rotated right by four.
- R7: A port reset (req_op = 0) gives six TCK cycles. TMS and TDI are 1 on the first five, and TMS is 0 on the sixth. rsp_data is 0.
- R8: After the six reset cycles, TMS is set high. Then, with TCK held low, TMS goes low for FUSE_HOLD system clocks, high for FUSE_HOLD, low for FUSE_HOLD again, and finally back to 1. That gives exactly two low pulses.
- R9: Each TCK phase, high or low, lasts TCK_HALF system clocks. TCK is 0 whenever busy is 0.
- R10: busy goes high in the cycle after a request is accepted. done is a one-cycle pulse, and busy is 0 in the cycle done is 1.
- R11: A request raised while busy is 1 is ignored: the running scan is unchanged, and no new scan starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_op | input | 2 | 0 port reset, 1 IR scan, 2 DR 16-bit, 3 DR 20-bit |
| req_data | input | 20 | Word to shift out, low L bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 20 | Captured word, valid with done |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
If the step counter or the state is wrong, it shows up first at the TMS pins: the recorded TMS pattern gets an extra or missing cycle, so the TCK count per operation goes off within one scan. If the shift register is misaligned, the TDI bit order is wrong and rsp_data is corrupted by the end of the same scan. If the 20-bit rotation is wrong, only the returned word for 20-bit scans is affected. A faulty fuse timer changes the length or number of the TMS low pulses that follow a port reset.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
    typedef enum logic [1:0] {
        OP_PRST = 2'd0,
        OP_IR   = 2'd1,
        OP_DRS  = 2'd2,
        OP_DRL  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_NAV, S_SHIFT, S_EXIT, S_PRST, S_FUSE
    } st_e;
endpackage

// File: rtl/jsm_tick_gen.sv
module jsm_tick_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(HALF - 1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    generate
        if (HALF > 1) begin : g_spacing
            // R9
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/jsm_reorder.sv
module jsm_reorder #(
    parameter int W   = 20,
    parameter int ROT = 4
) (
    input  logic [W-1:0] raw,
    input  logic         rot_en,
    output logic [W-1:0] out
);
    generate
        if (ROT > 0 && ROT < W) begin : g_rot
            assign out = rot_en ? {raw[ROT-1:0], raw[W-1:ROT]} : raw;
        end else begin : g_pass
            assign out = raw;
        end
    endgenerate
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master #(
    parameter int TCK_HALF  = 4,
    parameter int FUSE_HOLD = 1000,
    parameter int IR_BITS   = 8,
    parameter int DR_SHORT  = 16,
    parameter int DR_LONG   = 20,
    parameter int ROT       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [DR_LONG-1:0]   req_data,
    output logic                 busy,
    output logic                 done,
    output logic [DR_LONG-1:0]   rsp_data,
    output logic                 tck,
    output logic                 tms,
    output logic                 tdi,
    input  logic                 tdo
);
    import jsm_pkg::*;

    localparam int DW = DR_LONG;
    localparam int SW = $clog2(DW + 1);
    localparam int FW = $clog2(FUSE_HOLD + 1);
    localparam int RST_CYC = 6;

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic          ph;
        logic          tms;
        logic          tdi;
        logic [SW-1:0] step;
        logic [DW-1:0] sh;
        logic [1:0]    fsub;
        logic [FW-1:0] fcnt;
        logic          done;
        logic [DW-1:0] rsp;
    } regs_t;

    regs_t q, n;

    function automatic logic [SW-1:0] len_of(op_e o);
        case (o)
            OP_IR:   len_of = SW'(IR_BITS);
            OP_DRS:  len_of = SW'(DR_SHORT);
            default: len_of = SW'(DR_LONG);
        endcase
    endfunction

    function automatic logic [DW-1:0] mask_of(op_e o);
        mask_of = (DW'(1) << len_of(o)) - DW'(1);
    endfunction

    logic          run, tick;
    logic [SW-1:0] msb_i;
    logic [SW-1:0] nav_last;
    logic [DW-1:0] shifted, masked, reo;
    op_e           req_op_e;

    assign req_op_e = op_e'(req_op);
    assign run      = (q.st == S_NAV) || (q.st == S_SHIFT) ||
                      (q.st == S_EXIT) || (q.st == S_PRST);
    assign msb_i    = len_of(q.op) - SW'(1);
    assign nav_last = (q.op == OP_IR) ? SW'(3) : SW'(2);
    assign shifted  = {q.sh[DW-2:0], tdo};
    assign masked   = q.sh & mask_of(q.op);

    jsm_tick_gen #(.HALF(TCK_HALF)) i_tick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    jsm_reorder #(.W(DW), .ROT(ROT)) i_reo (
        .raw   (masked),
        .rot_en(q.op == OP_DRL),
        .out   (reo)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                n.ph = 1'b0;
                if (req_valid) begin
                    n.op   = req_op_e;
                    n.step = '0;
                    n.tms  = 1'b1;
                    n.tdi  = 1'b1;
                    n.sh   = req_data & mask_of(req_op_e);
                    n.st   = (req_op_e == OP_PRST) ? S_PRST : S_NAV;
                end
            end
            S_FUSE: begin
                if (q.fcnt == FW'(FUSE_HOLD - 1)) begin
                    n.fcnt = '0;
                    if (q.fsub == 2'd3) begin
                        n.tms  = 1'b1;
                        n.done = 1'b1;
                        n.rsp  = '0;
                        n.st   = S_IDLE;
                    end else begin
                        n.fsub = q.fsub + 2'd1;
                        n.tms  = q.fsub[0];
                    end
                end else begin
                    n.fcnt = q.fcnt + FW'(1);
                end
            end
            default: begin
                if (tick && !q.ph) begin
                    n.ph = 1'b1;
                end else if (tick) begin
                    n.ph = 1'b0;
                    case (q.st)
                        S_NAV: begin
                            if (q.step == nav_last) begin
                                n.st   = S_SHIFT;
                                n.step = '0;
                                n.tms  = 1'b0;
                                n.tdi  = q.sh[msb_i];
                            end else begin
                                n.step = q.step + SW'(1);
                                n.tms  = (q.op == OP_IR) && (q.step == '0);
                            end
                        end
                        S_SHIFT: begin
                            n.sh = shifted;
                            if (q.step == msb_i) begin
                                n.st  = S_EXIT;
                                n.tms = 1'b0;
                            end else begin
                                n.step = q.step + SW'(1);
                                n.tdi  = shifted[msb_i];
                                n.tms  = (q.step + SW'(1)) == msb_i;
                            end
                        end
                        S_EXIT: begin
                            n.rsp  = reo;
                            n.done = 1'b1;
                            n.st   = S_IDLE;
                        end
                        S_PRST: begin
                            if (q.step == SW'(RST_CYC - 1)) begin
                                n.st   = S_FUSE;
                                n.fsub = 2'd0;
                                n.fcnt = '0;
                                n.tms  = 1'b1;
                            end else begin
                                n.step = q.step + SW'(1);
                                n.tms  = (q.step + SW'(1)) != SW'(RST_CYC - 1);
                                n.tdi  = 1'b1;
                            end
                        end
                        default: n.st = S_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.st  <= S_IDLE;
            q.op  <= OP_PRST;
            q.tms <= 1'b1;
            q.tdi <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign rsp_data = q.rsp;
    assign tck      = q.ph;
    assign tms      = q.tms;
    assign tdi      = q.tdi;

    // R9
    tck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);
    // R9
    tck_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tck) |-> $past(tick));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8
    fuse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_FUSE) |-> !tck);
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(q.op));
    // R3
    shift_tms_chk: assert property (@(posedge clk) disable iff (rst)
        (q.st == S_SHIFT && q.step != msb_i) |-> !tms);
endmodule

// File: tb/test_jtag_scan_master.sv
module test_jtag_scan_master;
    localparam int HALF = 2;
    localparam int HOLD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_data = '0;
    logic        tdo = 1'b0;
    logic        busy, done, tck, tms, tdi;
    logic [19:0] rsp_data;

    always #5 clk = ~clk;

    jtag_scan_master #(.TCK_HALF(HALF), .FUSE_HOLD(HOLD)) i_jtag_scan_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .done(done), .rsp_data(rsp_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // target model state
    logic [1:0]  cur_op = 2'd0;
    logic [19:0] cur_resp = '0;
    int          cur_base = 0;
    int          ecount = 0;
    logic        tms_rec [64];
    logic        tdi_rec [64];

    function automatic int len_of(input logic [1:0] op);
        case (op)
            2'd1: return 8;
            2'd2: return 16;
            2'd3: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic int nav_of(input logic [1:0] op);
        return (op == 2'd1) ? 4 : 3;
    endfunction

    function automatic logic tdo_for(input int e);
        int j;
        j = e - cur_base - nav_of(cur_op);
        if (cur_op != 2'd0 && j >= 0 && j < len_of(cur_op))
            return cur_resp[len_of(cur_op) - 1 - j];
        return 1'b0;
    endfunction

    always @(posedge tck) begin
        tms_rec[ecount & 63] = tms;
        tdi_rec[ecount & 63] = tdi;
        tdo <= tdo_for(ecount);
        ecount = ecount + 1;
    end

    int   hi_total = 0;
    int   fuse_low = 0;
    int   fuse_falls = 0;
    logic prev_tms = 1'b1;

    always @(negedge clk) begin
        if (tck) hi_total = hi_total + 1;
        if (cur_op == 2'd0 && busy && !tck && (ecount - cur_base) == 6) begin
            if (!tms) fuse_low = fuse_low + 1;
            if (prev_tms && !tms) fuse_falls = fuse_falls + 1;
        end
        prev_tms = tms;
    end

    function automatic logic exp_tms(input logic [1:0] op, input int i);
        int nav, len;
        if (op == 2'd0) return (i < 5);
        nav = nav_of(op);
        len = len_of(op);
        if (i < nav) return (op == 2'd1) ? (i < 2) : (i == 0);
        if (i < nav + len) return (i == nav + len - 1);
        return 1'b0;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [19:0] data,
                          input logic [19:0] resp, input bit poke);
        int hi0, fl0, ff0, ncyc, n, bad_tms, bad_tdi, len, nav;
        logic [19:0] exp_rsp;
        cur_op   = op;
        cur_resp = resp;
        cur_base = ecount;
        hi0 = hi_total; fl0 = fuse_low; ff0 = fuse_falls;
        len = len_of(op);
        nav = nav_of(op);
        ncyc = (op == 2'd0) ? 6 : nav + len + 1;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (poke) begin
            req_valid = 1'b1; req_op = op ^ 2'd1; req_data = ~data;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R10 done seen", done, 1);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        case (op)
            2'd0: exp_rsp = '0;
            2'd1: exp_rsp = {12'd0, resp[7:0]};
            2'd2: exp_rsp = {4'd0, resp[15:0]};
            default: exp_rsp = {resp[3:0], resp[19:4]};
        endcase
        chk(rsp_data == exp_rsp, (op == 2'd3) ? "R6 reordered capture" : "R5 capture",
            rsp_data, exp_rsp);
        chk((ecount - cur_base) == ncyc, (op == 2'd0) ? "R7 tck count" :
            (op == 2'd1) ? "R2 tck count" : "R3 tck count", ecount - cur_base, ncyc);
        bad_tms = 0; bad_tdi = 0;
        for (int i = 0; i < ncyc; i++) begin
            if (tms_rec[(cur_base + i) & 63] !== exp_tms(op, i)) bad_tms++;
            if (op == 2'd0) begin
                if (i < 5 && tdi_rec[(cur_base + i) & 63] !== 1'b1) bad_tdi++;
            end else if (i >= nav && i < nav + len) begin
                if (tdi_rec[(cur_base + i) & 63] !== data[len - 1 - (i - nav)]) bad_tdi++;
            end
        end
        chk(bad_tms == 0, (op == 2'd0) ? "R7 tms pattern" :
            (op == 2'd1) ? "R2 tms pattern" : "R3 tms pattern", bad_tms, 0);
        chk(bad_tdi == 0, (op == 2'd0) ? "R7 tdi high" : "R4 tdi msb first", bad_tdi, 0);
        chk((hi_total - hi0) == HALF * ncyc, "R9 tck high time", hi_total - hi0, HALF * ncyc);
        if (op == 2'd0) begin
            chk((fuse_low - fl0) == 2 * HOLD, "R8 fuse low time", fuse_low - fl0, 2 * HOLD);
            chk((fuse_falls - ff0) == 2, "R8 fuse pulses", fuse_falls - ff0, 2);
            chk(tms == 1'b1, "R8 tms high after fuse", tms, 1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0 && tck == 1'b0, "R11 no late start", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        chk(done == 1'b0, "R1 done at reset", done, 0);
        chk(tck == 1'b0, "R1 tck at reset", tck, 0);
        chk(tms == 1'b1, "R1 tms at reset", tms, 1);

        run_op(2'd0, 20'h0, 20'h0, 1'b0);
        for (int v = 0; v < 256; v++)
            run_op(2'd1, 20'(v), 20'((v * 37 + 11) & 8'hFF), v[4]);
        for (int v = 0; v < 48; v++)
            run_op(2'd2, 20'((v * 1021 + 3) & 16'hFFFF), 20'((v * 4093 + 7) & 16'hFFFF), v[2]);
        run_op(2'd2, 20'hFFFF, 20'h0000, 1'b0);
        run_op(2'd2, 20'h0000, 20'hFFFF, 1'b0);
        for (int v = 0; v < 48; v++)
            run_op(2'd3, 20'((v * 40961 + 5) & 20'hFFFFF), 20'((v * 65537 + 9) & 20'hFFFFF), v[1]);
        run_op(2'd3, 20'hFFFFF, 20'h0000F, 1'b0);
        run_op(2'd3, 20'h80001, 20'hF0000, 1'b0);
        run_op(2'd0, 20'hABCDE, 20'h0, 1'b1);
        run_op(2'd1, 20'hA5, 20'h3C, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule